// File: doc/BRIEF.md
# Lane-Selective Widening Carry-Less Multiplier

This unit multiplies two 64-bit words lane by lane over GF(2), with no carries, and doubles the width of each product. The word is split into fixed containers that are twice as wide as the source element. A one-bit size control chooses the container layout: 16-bit containers holding bytes, or 32-bit containers holding halfwords. A one-bit pick control chooses which element of each container is used: the lower one or the upper one. Each selected pair is multiplied carry-less. The double-width product then fills the whole container in the output word.

Typical use is inside a vector datapath. It serves polynomial-multiply instructions, CRC folding and GF(2) hashing steps that process even or odd elements in separate passes. A beat enters with `in_valid`. The product word and `out_valid` appear one clock later. The result register keeps its value until the next accepted beat.

Top module: `pmul_widen_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid` reads 0 and `result` reads all zeros. Reset is synchronous and active high.
- R2: `out_valid` is high exactly in the cycle that follows a clock edge at which `in_valid` was high, and low otherwise.
- R3: `result` takes the product of a beat at the edge where `in_valid` is high. At an edge where `in_valid` is low it keeps its previous value.
- R4: With `lane_size` = 0 (byte mode), the word is four 16-bit containers. Container k spans bits [16k+15:16k]. The product of the selected bytes of container k is written to those bits.
- R5: With `lane_size` = 1 (halfword mode), the word is two 32-bit containers. Container k spans bits [32k+31:32k]. It receives the 32-bit product of the selected halfwords.
- R6: With `lane_pick` = 0 (even), the lower element of each container is used. The upper element of each container has no effect on `result`.
- R7: With `lane_pick` = 1 (odd), the upper element of each container is used. The lower element has no effect on `result`.
- R8: Each product is the XOR of the multiplicand shifted left by i, over every set bit i of the multiplier. For example, 0xff times 0xff gives 0x5555. A zero operand gives zero, and a multiplier of 1 returns the multiplicand.
- R9: The top bit of every container in `result` is always 0. An n-by-n carry-less product needs at most 2n-1 bits, so no product reaches into a neighbouring container.
- R10: Beats on consecutive cycles may change size and pick from one beat to the next. Each result reflects only the controls sampled with its own beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat strobe; operands and controls are sampled when high |
| op_a | input | 64 | Multiplicand word |
| op_b | input | 64 | Multiplier word |
| lane_size | input | 1 | 0 = byte elements in 16-bit containers, 1 = halfword elements in 32-bit containers |
| lane_pick | input | 1 | 0 = lower (even) element, 1 = upper (odd) element of each container |
| out_valid | output | 1 | High one cycle after an accepted beat |
| result | output | 64 | Widened carry-less products, one per container |

## Verification
In a single cycle the unit can present the previous beat's product while it captures a new beat whose size and pick differ. The bench provokes this with back-to-back beats that switch mode every cycle. It compares each cycle's output against a bit-serial model that has seen exactly the same history, so a control that leaks into the wrong beat shows up at once. The other overlap is between holding and loading. Idle cycles are interleaved at random between beats, and the model checks that an idle edge leaves the previous product untouched while a valid edge replaces it.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    localparam int BYTE_ELEM_W = 8;
    localparam int HALF_ELEM_W = 16;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } lane_size_e;

    typedef enum logic {
        PICK_EVEN = 1'b0,
        PICK_ODD  = 1'b1
    } lane_pick_e;

    typedef struct packed {
        lane_size_e size;
        lane_pick_e pick;
    } lane_mode_t;

    function automatic int elem_width(input lane_size_e sz);
        return (sz == SZ_HALF) ? HALF_ELEM_W : BYTE_ELEM_W;
    endfunction

    function automatic int pick_offset(input lane_pick_e pk, input int ew);
        return (pk == PICK_ODD) ? ew : 0;
    endfunction

endpackage

// File: rtl/pmul_operand_pick.sv
module pmul_operand_pick
    import pmul_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 8
) (
    input  logic [DATA_W-1:0]                     word,
    input  lane_pick_e                            pick,
    output logic [DATA_W/(2*ELEM_W)-1:0][ELEM_W-1:0] elems
);
    localparam int CONT_W   = 2 * ELEM_W;
    localparam int NUM_CONT = DATA_W / CONT_W;

    for (genvar k = 0; k < NUM_CONT; k++) begin : g_cont
        logic [ELEM_W-1:0] lo_elem;
        logic [ELEM_W-1:0] hi_elem;
        assign lo_elem  = word[k*CONT_W +: ELEM_W];
        assign hi_elem  = word[k*CONT_W + ELEM_W +: ELEM_W];
        assign elems[k] = (pick == PICK_ODD) ? hi_elem : lo_elem;
    end

endmodule

// File: rtl/pmul_clmul_lane.sv
module pmul_clmul_lane #(
    parameter int ELEM_W = 8
) (
    input  logic [ELEM_W-1:0]   mcand,
    input  logic [ELEM_W-1:0]   mplier,
    output logic [2*ELEM_W-1:0] prod
);
    localparam int PROD_W = 2 * ELEM_W;

    logic [PROD_W-1:0] acc;
    logic [PROD_W-1:0] mcand_wide;

    assign mcand_wide = {{ELEM_W{1'b0}}, mcand};

    always_comb begin
        acc = '0;
        for (int i = 0; i < ELEM_W; i++) begin
            if (mplier[i]) begin
                acc = acc ^ (mcand_wide << i);
            end
        end
    end

    assign prod = acc;

    // R8: a unit multiplier must return the multiplicand unchanged
    always_comb begin
        if (mplier == ELEM_W'(1)) begin
            p_unit_mult_r8: assert (prod == mcand_wide);
        end
    end

endmodule

// File: rtl/pmul_width_slice.sv
module pmul_width_slice
    import pmul_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  lane_pick_e        pick,
    output logic [DATA_W-1:0] word
);
    localparam int CONT_W   = 2 * ELEM_W;
    localparam int NUM_CONT = DATA_W / CONT_W;

    logic [NUM_CONT-1:0][ELEM_W-1:0] a_elems;
    logic [NUM_CONT-1:0][ELEM_W-1:0] b_elems;

    pmul_operand_pick #(.DATA_W(DATA_W), .ELEM_W(ELEM_W)) u_pick_a (
        .word  (op_a),
        .pick  (pick),
        .elems (a_elems)
    );

    pmul_operand_pick #(.DATA_W(DATA_W), .ELEM_W(ELEM_W)) u_pick_b (
        .word  (op_b),
        .pick  (pick),
        .elems (b_elems)
    );

    for (genvar k = 0; k < NUM_CONT; k++) begin : g_lane
        logic [CONT_W-1:0] lane_prod;
        pmul_clmul_lane #(.ELEM_W(ELEM_W)) u_lane (
            .mcand  (a_elems[k]),
            .mplier (b_elems[k]),
            .prod   (lane_prod)
        );
        assign word[k*CONT_W +: CONT_W] = lane_prod;
    end

endmodule

// File: rtl/pmul_widen_top.sv
module pmul_widen_top
    import pmul_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              lane_size,
    input  logic              lane_pick,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_POINT = DATA_W / 2;

    lane_mode_t        mode;
    logic [DATA_W-1:0] byte_word;
    logic [DATA_W-1:0] half_word;
    logic [DATA_W-1:0] next_word;
    logic              valid_q;
    logic [DATA_W-1:0] result_q;

    assign mode.size = lane_size_e'(lane_size);
    assign mode.pick = lane_pick_e'(lane_pick);

    pmul_width_slice #(.DATA_W(DATA_W), .ELEM_W(BYTE_ELEM_W)) u_byte_slice (
        .op_a (op_a),
        .op_b (op_b),
        .pick (mode.pick),
        .word (byte_word)
    );

    pmul_width_slice #(.DATA_W(DATA_W), .ELEM_W(HALF_ELEM_W)) u_half_slice (
        .op_a (op_a),
        .op_b (op_b),
        .pick (mode.pick),
        .word (half_word)
    );

    assign next_word = (mode.size == SZ_HALF) ? half_word : byte_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                result_q <= next_word;
            end
        end
    end

    assign out_valid = valid_q;
    assign result    = result_q;

    // R2: an accepted beat raises out_valid on the next cycle
    p_valid_on_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2: no beat, no out_valid
    p_valid_off_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3: idle edges keep the product
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R9: container top bits shared by both layouts stay clear
    p_no_spill_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!result[DATA_W-1] && !result[HALF_POINT-1]));

    // R8: a zero multiplicand yields a zero product
    p_zero_op_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_a == '0)) |=> (result == '0));

endmodule

// File: tb/pmul_widen_top_tb.sv
`timescale 1ns/1ps
module pmul_widen_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic        lane_size;
    logic        lane_pick;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic        exp_valid;
    logic [63:0] exp_result;

    always #5 clk = ~clk;

    pmul_widen_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .lane_size (lane_size),
        .lane_pick (lane_pick),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [63:0] ref_model(input logic [63:0] a, input logic [63:0] b,
                                              input logic sz, input logic pk);
        int ew = sz ? 16 : 8;
        int nc = 64 / (2 * ew);
        logic [63:0] mask = sz ? 64'h0000_0000_0000_ffff : 64'h0000_0000_0000_00ff;
        logic [63:0] r = '0;
        for (int c = 0; c < nc; c++) begin
            logic [63:0] x = (a >> (c * 2 * ew + (pk ? ew : 0))) & mask;
            logic [63:0] y = (b >> (c * 2 * ew + (pk ? ew : 0))) & mask;
            logic [63:0] p = '0;
            for (int i = 0; i < ew; i++) begin
                if (y[i]) p = p ^ (x << i);
            end
            r = r | (p << (c * 2 * ew));
        end
        return r;
    endfunction

    task automatic check_out(input string tag);
        checks++;
        if (out_valid !== exp_valid || result !== exp_result) begin
            errors++;
            $display("FAIL %s: valid=%0b result=%016h expected valid=%0b result=%016h",
                     tag, out_valid, result, exp_valid, exp_result);
        end
    endtask

    task automatic check_value(input string tag, input logic [63:0] want);
        checks++;
        if (result !== want) begin
            errors++;
            $display("FAIL %s: result=%016h expected %016h", tag, result, want);
        end
    endtask

    // drive one cycle, update the model at the edge, compare after it
    task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                        input logic sz, input logic pk, input string tag);
        @(negedge clk);
        in_valid  = v;
        op_a      = a;
        op_b      = b;
        lane_size = sz;
        lane_pick = pk;
        @(posedge clk);
        exp_valid = v;
        if (v) exp_result = ref_model(a, b, sz, pk);
        #1;
        check_out(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
        lane_size = 1'b0; lane_pick = 1'b0;
        exp_valid = 1'b0; exp_result = '0;
        repeat (3) @(posedge clk);
        #1;
        check_out("R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_out("R1 after release");

        // R4 byte mode, known value 3*3 = 5 in container 0
        step(1'b1, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0003, 1'b0, 1'b0, "R4 byte even");
        check_value("R4 known 0x3*0x3", 64'h0000_0000_0000_0005);
        // R8 all ones: 0xff*0xff = 0x5555 in every container; R9 no spill
        step(1'b1, 64'h00ff_00ff_00ff_00ff, 64'h00ff_00ff_00ff_00ff, 1'b0, 1'b0, "R8 all ones byte");
        check_value("R8 0xff*0xff", 64'h5555_5555_5555_5555);
        checks++;
        if (result[15] || result[31] || result[47] || result[63]) begin
            errors++;
            $display("FAIL R9: result=%016h expected container top bits 0", result);
        end
        // R5 halfword mode known: 0x8000*0x8000 = 0x40000000
        step(1'b1, 64'h0000_0000_0000_8000, 64'h0000_8000_0000_8000, 1'b1, 1'b0, "R5 half even");
        check_value("R5 known", 64'h0000_0000_4000_0000);
        // R6 upper elements ignored in even mode
        step(1'b1, 64'hff00_ff00_ff00_ff00, 64'hff00_ff00_ff00_ff00, 1'b0, 1'b0, "R6 even ignores upper");
        check_value("R6 zero result", 64'h0);
        // R7 lower elements ignored in odd mode
        step(1'b1, 64'h0000_ffff_0000_ffff, 64'h0000_ffff_0000_ffff, 1'b1, 1'b1, "R7 odd ignores lower");
        check_value("R7 zero result", 64'h0);
        step(1'b1, 64'h0300_0000_0000_0000, 64'h0300_0000_0000_0000, 1'b0, 1'b1, "R7 odd byte");
        check_value("R7 known", 64'h0005_0000_0000_0000);
        // R8 zero and unit operands
        step(1'b1, 64'h0, 64'hffff_ffff_ffff_ffff, 1'b1, 1'b1, "R8 zero operand");
        step(1'b1, 64'h1234_5678_9abc_def0, 64'h0001_0001_0001_0001, 1'b1, 1'b1, "R8 unit multiplier");
        // single-bit operands across all positions
        for (int k = 0; k < 16; k++) begin
            step(1'b1, 64'h1 << k, 64'h1 << (15 - k), 1'b1, 1'b0, "R8 single bit half");
            step(1'b1, 64'h1 << (k + 16), 64'h1 << (31 - k), 1'b1, 1'b1, "R9 single bit half odd");
        end
        // R3 idle hold, R2 out_valid low
        step(1'b0, 64'hdead_beef_dead_beef, 64'hffff_ffff_ffff_ffff, 1'b0, 1'b1, "R3 idle hold");
        step(1'b0, 64'h0, 64'h0, 1'b1, 1'b0, "R2 idle valid low");
        // R10 back-to-back mode switches
        for (int m = 0; m < 8; m++) begin
            step(1'b1, 64'hffff_ffff_ffff_ffff, 64'h8421_1248_f0f0_0f0f,
                 m[0], m[1], "R10 mode switch");
        end
        // random traffic with random idle cycles
        for (int n = 0; n < 2000; n++) begin
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = {$urandom, $urandom};
            logic [2:0]  ctl = 3'($urandom);
            step(($urandom % 4) != 0, ra, rb, ctl[0], ctl[1], "R10 random");
        end
        // reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        exp_valid = 1'b0; exp_result = '0;
        #1;
        check_out("R1 reset again");
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule